// File: doc/BRIEF.md
# Per-Core Power-Up Reset Sequencer

This block brings a single core of a four-core cluster out of power-off. It drives the core's reset lines, its power-gate bit and a request to the staged power-switch sequencer, always in one fixed order. A start pulse carries the core index and a type flag, which is either little or big. Some steps differ by type. A little core also works its L1 reset-disable bit and its trace reset. A big core leaves both of those alone and releases its NEON reset at the end instead.

All reset outputs are active low. Clearing a bit asserts that reset, and setting the bit releases it. Each output is a vector with one bit per core, so the block holds the state of every core and changes only the bits of the core it is working on. The settle wait after the power gate opens is a cycle count, `SETTLE_CYCLES`. Its default is 5000 cycles, which is 20 us at 250 MHz. When the sequence is complete, `done_o` pulses for one cycle. A start with an index the cluster does not have raises `err_o` for one cycle and changes nothing.

Top module: `core_pwrup_seq`

## Requirements
- R1: After reset, por_n_o, dbg_rst_n_o and trc_rst_n_o are all ones. core_rst_n_o and neon_rst_n_o are all zeros. l1_rst_dis_o and pgate_o are all ones. sw_req_o, done_o and err_o are 0.
- R2: A start with an index below NUM_CORES, sampled while idle, clears bit idx of por_n_o at that edge. No other output bit changes.
- R3: At the next edge, a little core (big_i=0) clears bit idx of l1_rst_dis_o. For a big core, l1_rst_dis_o stays unchanged.
- R4: At the next edge, bit idx of dbg_rst_n_o is cleared. For a little core only, bit idx of trc_rst_n_o is also cleared. sw_req_o rises at the same edge.
- R5: sw_req_o stays high until sw_done_i is sampled high. At that edge, sw_req_o falls and bit idx of pgate_o clears. sw_done_i has no effect at any other time.
- R6: Bit idx of por_n_o is set exactly SETTLE_CYCLES edges after the edge that cleared the power gate. It stays low until then.
- R7: At the next edge, bits idx of dbg_rst_n_o and core_rst_n_o are set. A little core also sets trc_rst_n_o[idx]. A big core sets neon_rst_n_o[idx] instead. done_o is high for exactly that one cycle.
- R8: A start with an index of NUM_CORES or more, sampled while idle, makes err_o high for one cycle. It changes no other output.
- R9: A start sampled while a sequence runs, including the final release edge, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a bring-up (sampled while idle) |
| idx_i | input | IDX_W | Core index to bring up |
| big_i | input | 1 | Core type: 1 big, 0 little |
| sw_done_i | input | 1 | Power-switch sequencer finished |
| sw_req_o | output | 1 | Request to the power-switch sequencer |
| por_n_o | output | NUM_CORES | Per-core power-on reset, active low |
| dbg_rst_n_o | output | NUM_CORES | Per-core debug reset, active low |
| trc_rst_n_o | output | NUM_CORES | Per-core trace reset, active low |
| core_rst_n_o | output | NUM_CORES | Per-core core reset, active low |
| neon_rst_n_o | output | NUM_CORES | Per-core NEON reset, active low |
| l1_rst_dis_o | output | NUM_CORES | Per-core L1 reset-disable bit |
| pgate_o | output | NUM_CORES | Per-core power gate, 1 = gated |
| done_o | output | 1 | One-cycle pulse at the final release |
| err_o | output | 1 | One-cycle pulse on a rejected index |

## Verification
Two events can land in the same cycle. The first is a new start arriving at the final release edge, when done_o is being raised. The second is a start or a stray switch-done arriving while the block waits on the switch sequencer. The bench holds start_i high with a different core index across the release edge and drops it at the falling edge where done_o is first seen. It also drives starts during the switch wait. It then compares every output vector with its own model, which must show that the second core's bits never moved and that the first core finished normally.

// File: rtl/core_pwrup_pkg.sv
package core_pwrup_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1,
    ST_DBG,
    ST_SWITCH,
    ST_SETTLE,
    ST_RELEASE
  } seq_state_e;

  // one strobe per ordered step; at most one is high in a cycle
  typedef struct packed {
    logic por_clr;
    logic l1_clr;
    logic dbg_clr;
    logic gate_clr;
    logic por_set;
    logic final_rel;
  } step_t;

endpackage

// File: rtl/core_pwrup_ctrl.sv
module core_pwrup_ctrl
  import core_pwrup_pkg::*;
#(
  parameter int NUM_CORES     = 4,
  parameter int IDX_W         = 3,
  parameter int SETTLE_CYCLES = 5000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic                 big_i,
  input  logic                 sw_done_i,
  output step_t                step_o,
  output logic [NUM_CORES-1:0] sel_o,
  output logic                 big_o,
  output logic                 sw_req_o,
  output logic                 done_o,
  output logic                 err_o
);

  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  seq_state_e         state_q;
  logic [IDX_W-1:0]   idx_q;
  logic               big_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               idx_ok;
  logic               take;
  logic [IDX_W-1:0]   idx_cur;

  assign idx_ok  = ({1'b0, idx_i} < (IDX_W+1)'(NUM_CORES));
  assign take    = (state_q == ST_IDLE) && start_i;
  assign idx_cur = (state_q == ST_IDLE) ? idx_i : idx_q;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_sel
    assign sel_o[c] = (idx_cur == IDX_W'(c));
  end

  assign big_o = big_q;

  always_comb begin
    step_o           = '0;
    step_o.por_clr   = take && idx_ok;
    step_o.l1_clr    = (state_q == ST_L1);
    step_o.dbg_clr   = (state_q == ST_DBG);
    step_o.gate_clr  = (state_q == ST_SWITCH) && sw_done_i;
    step_o.por_set   = (state_q == ST_SETTLE) && (cnt_q == CNT_LAST);
    step_o.final_rel = (state_q == ST_RELEASE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      big_q    <= 1'b0;
      cnt_q    <= '0;
      sw_req_o <= 1'b0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (take) begin
            if (idx_ok) begin
              idx_q   <= idx_i;
              big_q   <= big_i;
              state_q <= ST_L1;
            end else begin
              err_o <= 1'b1;
            end
          end
        end
        ST_L1: state_q <= ST_DBG;
        ST_DBG: begin
          sw_req_o <= 1'b1;
          state_q  <= ST_SWITCH;
        end
        ST_SWITCH: begin
          if (sw_done_i) begin
            sw_req_o <= 1'b0;
            cnt_q    <= '0;
            state_q  <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_LAST) state_q <= ST_RELEASE;
        end
        ST_RELEASE: begin
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9
  step_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(step_o));

  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (state_q == ST_IDLE) && !done_o);

  // R7
  done_noreq_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !sw_req_o);

endmodule

// File: rtl/core_pwrup_regs.sv
module core_pwrup_regs
  import core_pwrup_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  step_t                step_i,
  input  logic [NUM_CORES-1:0] sel_i,
  input  logic                 big_i,
  input  logic                 sw_done_i,
  input  logic                 sw_req_i,
  output logic [NUM_CORES-1:0] por_n_o,
  output logic [NUM_CORES-1:0] dbg_rst_n_o,
  output logic [NUM_CORES-1:0] trc_rst_n_o,
  output logic [NUM_CORES-1:0] core_rst_n_o,
  output logic [NUM_CORES-1:0] neon_rst_n_o,
  output logic [NUM_CORES-1:0] l1_rst_dis_o,
  output logic [NUM_CORES-1:0] pgate_o
);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic hit;
    assign hit = sel_i[c];

    always_ff @(posedge clk) begin
      if (rst) begin
        por_n_o[c]      <= 1'b1;
        dbg_rst_n_o[c]  <= 1'b1;
        trc_rst_n_o[c]  <= 1'b1;
        core_rst_n_o[c] <= 1'b0;
        neon_rst_n_o[c] <= 1'b0;
        l1_rst_dis_o[c] <= 1'b1;
        pgate_o[c]      <= 1'b1;
      end else if (hit) begin
        if (step_i.por_clr) por_n_o[c] <= 1'b0;
        if (step_i.por_set) por_n_o[c] <= 1'b1;
        if (step_i.l1_clr && !big_i) l1_rst_dis_o[c] <= 1'b0;
        if (step_i.dbg_clr) begin
          dbg_rst_n_o[c] <= 1'b0;
          if (!big_i) trc_rst_n_o[c] <= 1'b0;
        end
        if (step_i.gate_clr) pgate_o[c] <= 1'b0;
        if (step_i.final_rel) begin
          dbg_rst_n_o[c]  <= 1'b1;
          core_rst_n_o[c] <= 1'b1;
          if (big_i) neon_rst_n_o[c] <= 1'b1;
          else       trc_rst_n_o[c]  <= 1'b1;
        end
      end
    end
  end

  // R5
  gate_open_chk: assert property (@(posedge clk) disable iff (rst)
    ((~pgate_o & $past(pgate_o)) != '0) |-> $past(sw_done_i && sw_req_i));

  // R6
  por_after_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (((por_n_o & ~$past(por_n_o)) & pgate_o) == '0));

  // R4
  trc_little_chk: assert property (@(posedge clk) disable iff (rst)
    ((~trc_rst_n_o & $past(trc_rst_n_o)) != '0) |-> !$past(big_i));

endmodule

// File: rtl/core_pwrup_seq.sv
module core_pwrup_seq
  import core_pwrup_pkg::*;
#(
  parameter int NUM_CORES     = 4,
  parameter int IDX_W         = 3,
  parameter int SETTLE_CYCLES = 5000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic                 big_i,
  input  logic                 sw_done_i,
  output logic                 sw_req_o,
  output logic [NUM_CORES-1:0] por_n_o,
  output logic [NUM_CORES-1:0] dbg_rst_n_o,
  output logic [NUM_CORES-1:0] trc_rst_n_o,
  output logic [NUM_CORES-1:0] core_rst_n_o,
  output logic [NUM_CORES-1:0] neon_rst_n_o,
  output logic [NUM_CORES-1:0] l1_rst_dis_o,
  output logic [NUM_CORES-1:0] pgate_o,
  output logic                 done_o,
  output logic                 err_o
);

  step_t                step;
  logic [NUM_CORES-1:0] sel;
  logic                 big_sel;

  core_pwrup_ctrl #(
    .NUM_CORES     (NUM_CORES),
    .IDX_W         (IDX_W),
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .idx_i     (idx_i),
    .big_i     (big_i),
    .sw_done_i (sw_done_i),
    .step_o    (step),
    .sel_o     (sel),
    .big_o     (big_sel),
    .sw_req_o  (sw_req_o),
    .done_o    (done_o),
    .err_o     (err_o)
  );

  core_pwrup_regs #(
    .NUM_CORES (NUM_CORES)
  ) regs_i (
    .clk          (clk),
    .rst          (rst),
    .step_i       (step),
    .sel_i        (sel),
    .big_i        (big_sel),
    .sw_done_i    (sw_done_i),
    .sw_req_i     (sw_req_o),
    .por_n_o      (por_n_o),
    .dbg_rst_n_o  (dbg_rst_n_o),
    .trc_rst_n_o  (trc_rst_n_o),
    .core_rst_n_o (core_rst_n_o),
    .neon_rst_n_o (neon_rst_n_o),
    .l1_rst_dis_o (l1_rst_dis_o),
    .pgate_o      (pgate_o)
  );

  // R4
  req_in_dbg_chk: assert property (@(posedge clk) disable iff (rst)
    sw_req_o |-> (dbg_rst_n_o != '1) && (por_n_o != '1));

  // R8
  err_nochange_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $stable(por_n_o) && $stable(pgate_o) && $stable(dbg_rst_n_o)
              && $stable(l1_rst_dis_o) && !sw_req_o);

endmodule

// File: tb/core_pwrup_seq_tb_top.sv
module core_pwrup_seq_tb_top;

  localparam int NC     = 4;
  localparam int IW     = 3;
  localparam int SETTLE = 30;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [IW-1:0] idx_i = '0;
  logic          big_i = 1'b0;
  logic          sw_done_i = 1'b0;
  logic          sw_req_o, done_o, err_o;
  logic [NC-1:0] por_n_o, dbg_rst_n_o, trc_rst_n_o, core_rst_n_o;
  logic [NC-1:0] neon_rst_n_o, l1_rst_dis_o, pgate_o;

  logic [NC-1:0] e_por, e_dbg, e_trc, e_core, e_neon, e_l1, e_gate;
  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #2 clk = ~clk;

  core_pwrup_seq #(.NUM_CORES(NC), .IDX_W(IW), .SETTLE_CYCLES(SETTLE)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .idx_i(idx_i), .big_i(big_i),
    .sw_done_i(sw_done_i), .sw_req_o(sw_req_o), .por_n_o(por_n_o),
    .dbg_rst_n_o(dbg_rst_n_o), .trc_rst_n_o(trc_rst_n_o),
    .core_rst_n_o(core_rst_n_o), .neon_rst_n_o(neon_rst_n_o),
    .l1_rst_dis_o(l1_rst_dis_o), .pgate_o(pgate_o), .done_o(done_o),
    .err_o(err_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [NC-1:0] clr_bit(logic [NC-1:0] v, int i);
    logic [NC-1:0] r = v;
    r[i] = 1'b0;
    return r;
  endfunction

  function automatic logic [NC-1:0] set_bit(logic [NC-1:0] v, int i);
    logic [NC-1:0] r = v;
    r[i] = 1'b1;
    return r;
  endfunction

  task automatic chk(string req, string what, logic [NC-1:0] act, logic [NC-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req, logic req_e, logic done_e, logic err_e);
    chk(req, "por_n", por_n_o, e_por);
    chk(req, "dbg_n", dbg_rst_n_o, e_dbg);
    chk(req, "trc_n", trc_rst_n_o, e_trc);
    chk(req, "core_n", core_rst_n_o, e_core);
    chk(req, "neon_n", neon_rst_n_o, e_neon);
    chk(req, "l1dis", l1_rst_dis_o, e_l1);
    chk(req, "pgate", pgate_o, e_gate);
    chk(req, "sw_req", NC'(sw_req_o), NC'(req_e));
    chk(req, "done", NC'(done_o), NC'(done_e));
    chk(req, "err", NC'(err_o), NC'(err_e));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_seq(int idx, logic big, int delay, logic late_start);
    int early = 0;
    start_i = 1'b1; idx_i = IW'(idx); big_i = big;
    tick();
    start_i = 1'b0; big_i = ~big;
    e_por = clr_bit(e_por, idx);
    check_all("R2", 0, 0, 0);
    tick();
    if (!big) e_l1 = clr_bit(e_l1, idx);
    check_all("R3", 0, 0, 0);
    tick();
    e_dbg = clr_bit(e_dbg, idx);
    if (!big) e_trc = clr_bit(e_trc, idx);
    check_all("R4", 1, 0, 0);
    for (int k = 0; k < delay; k++) begin
      if (k == 1) begin start_i = 1'b1; idx_i = IW'((idx + 2) % NC); end
      tick();
      start_i = 1'b0;
      check_all("R9", 1, 0, 0);
    end
    sw_done_i = 1'b1;
    tick();
    sw_done_i = 1'b0;
    e_gate = clr_bit(e_gate, idx);
    check_all("R5", 0, 0, 0);
    for (int k = 1; k < SETTLE; k++) begin
      tick();
      if (por_n_o[idx] !== 1'b0) early++;
    end
    total++;
    if (early != 0) begin
      bad++;
      $display("FAIL R6 early por release actual=%0d expected=0", early);
    end
    tick();
    e_por = set_bit(e_por, idx);
    check_all("R6", 0, 0, 0);
    if (late_start) begin start_i = 1'b1; idx_i = IW'((idx + 1) % NC); end
    tick();
    start_i = 1'b0;
    e_dbg  = set_bit(e_dbg, idx);
    e_core = set_bit(e_core, idx);
    if (big) e_neon = set_bit(e_neon, idx);
    else     e_trc  = set_bit(e_trc, idx);
    check_all("R7", 0, 1, 0);
    tick();
    check_all(late_start ? "R9" : "R7", 0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'h1a2b3c4d));
    e_por = '1; e_dbg = '1; e_trc = '1; e_core = '0;
    e_neon = '0; e_l1 = '1; e_gate = '1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R1", 0, 0, 0);

    // stray switch-done while idle
    sw_done_i = 1'b1;
    tick();
    sw_done_i = 1'b0;
    check_all("R5", 0, 0, 0);

    // directed: little core 0, big core 3 with late start at release
    run_seq(0, 1'b0, 3, 1'b0);
    run_seq(3, 1'b1, 2, 1'b1);

    // rejected indices
    for (int bi = NC; bi < (1 << IW); bi++) begin
      start_i = 1'b1; idx_i = IW'(bi);
      tick();
      start_i = 1'b0;
      check_all("R8", 0, 0, 1);
      tick();
      check_all("R8", 0, 0, 0);
    end

    // random mix
    for (int n = 0; n < 12; n++) begin
      run_seq(int'($urandom % NC), logic'($urandom % 2), 2 + int'($urandom % 6),
              logic'($urandom % 2));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule